// File: doc/BRIEF.md
# Wired interrupt to message converter

This block turns a bank of level or edge wired interrupt lines into message-signalled interrupt writes. Pins are grouped into nodes of 128. Each pin has a trigger-type bit, a vector register holding a 12-bit device ID and a 10-bit event ID, and a pending bit. When a pin fires, its pending bit is set and the block issues exactly one message on a valid/ready output. The message carries the pin's device ID and event ID toward a doorbell address that is fixed by a parameter. The pin cannot send again until software clears its pending bit.

Software reaches the block through a 32-bit register port. The type and vector registers are addressed per node, with an index inside the node. The status-clear registers are addressed by a global pin number, and that numbering keeps its lowest 64 numbers reserved. When several pins are waiting, a round-robin arbiter chooses which one goes next.

Top module: `wim_top`

## Requirements
- R1: After reset every type, vector and pending bit is zero, `msg_valid` is low and every register reads as zero.
- R2: Node n, for n from 1 to NUM_NODES, occupies byte addresses n×0x1000 upward. The vector register of in-node pin i sits at node base + 0x200 + 4·i and holds the event ID in bits [21:12] and the device ID in bits [11:0]. Bits [31:22] read as zero.
- R3: The type word at node base + 4·(i/32) holds pin i at bit i mod 32. A 1 selects level-high triggering and a 0 selects rising-edge triggering. A write replaces the whole word.
- R4: In edge mode a 0-to-1 change of the synchronised input sets the pending bit and produces one message. If the input stays high after a clear, no new message is sent.
- R5: In level mode a high input sets the pending bit. After a clear the pin sends again if its input is still high, and stays quiet if the input is low.
- R6: A pin that has sent its message sends no further message, whatever its input does, until its pending bit is cleared.
- R7: Pin i of node n has global number g = 64 + 128·(n−1) + i. Its status sits at 0xA000 + 4·(g/32), bit g mod 32. Writing 1 clears the pending bit and writing 0 has no effect. A read returns the pending bits.
- R8: A message holds `msg_device_id`, `msg_event_id` and `msg_addr` (= DOORBELL) stable while `msg_valid` is high and `msg_ready` is low. The payload is the pin's vector register as it stood when the message was issued.
- R9: When several pins are waiting, the next one granted is the first waiting pin after the most recently granted pin, with the search wrapping round. After reset the search starts at pin 0.
- R10: The following read as zero and ignore writes: the reserved status words for global pins 0–63, the node-0 region, nodes above NUM_NODES, and status words beyond the last pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NUM_NODES·128 | Wired interrupt lines, local pin order |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 16 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high with `msg_valid` |
| msg_addr | output | ADDR_W | Fixed doorbell address |
| msg_device_id | output | 12 | Device ID of the message |
| msg_event_id | output | 10 | Event ID of the message |

## Verification
The hardest situation to reach from the ports is a round-robin grant that differs from a fixed-priority grant. The arbiter pointer has to be left beyond a low-numbered pin before two pins raise their lines in the same cycle. The bench first drains three pins in one burst, which leaves the pointer at pin 2. It then raises pins 0 and 6 together and expects pin 6 to be granted first. Holding `msg_ready` low while lines rise shows both that the output stays stable and that other pins queue up behind it.

// File: rtl/wim_pkg.sv
package wim_pkg;
    localparam int PINS_PER_NODE = 128;
    localparam int RESERVED_PINS = 64;
    localparam int EVT_W         = 10;
    localparam int DEV_W         = 12;
    localparam logic [15:0] CLR_BASE = 16'hA000;

    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [DEV_W-1:0] dev;
    } vec_t;
endpackage

// File: rtl/wim_pin_cell.sv
module wim_pin_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic level_i,
    input  logic clr_i,
    input  logic take_i,
    output logic pend_o,
    output logic req_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
        logic       pend;
        logic       sent;
    } cell_t;

    cell_t c_d, c_q;
    logic  hit;

    always_comb begin
        c_d      = c_q;
        c_d.sync = {c_q.sync[0], irq_i};
        c_d.prev = c_q.sync[1];
        hit      = level_i ? c_q.sync[1] : (c_q.sync[1] & ~c_q.prev);
        if (clr_i) begin
            c_d.pend = 1'b0;
            c_d.sent = 1'b0;
        end else begin
            if (hit)    c_d.pend = 1'b1;
            if (take_i) c_d.sent = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pend_o = c_q.pend;
    assign req_o  = c_q.pend & ~c_q.sent;

    // R6: a pin marked as sent is always still pending
    p_sent_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.sent |-> c_q.pend);
    // R6: the top only takes a pin that is requesting
    p_take_only_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> req_o);
endmodule

// File: rtl/wim_rr_arb.sv
module wim_rr_arb #(
    parameter int N = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_i,
    input  logic                 adv_i,
    output logic                 gnt_v_o,
    output logic [$clog2(N)-1:0] gnt_idx_o
);
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_t;

    arb_t a_d, a_q;
    int   cand;

    always_comb begin
        gnt_v_o   = 1'b0;
        gnt_idx_o = '0;
        cand      = 0;
        for (int k = 1; k <= N; k++) begin
            cand = int'(a_q.ptr) + k;
            if (cand >= N) cand = cand - N;
            if (!gnt_v_o && req_i[cand]) begin
                gnt_v_o   = 1'b1;
                gnt_idx_o = IDX_W'(cand);
            end
        end
        a_d = a_q;
        if (adv_i && gnt_v_o) a_d.ptr = gnt_idx_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q.ptr <= IDX_W'(N - 1);
        else        a_q     <= a_d;
    end

    // R9: a grant always points at a requesting pin
    p_grant_requested_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_v_o |-> req_i[gnt_idx_o]);
    // R9: a waiting pin is never left without a grant
    p_grant_when_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> gnt_v_o);
endmodule

// File: rtl/wim_top.sv
module wim_top
    import wim_pkg::*;
#(
    parameter int              NUM_NODES = 1,
    parameter int              ADDR_W    = 48,
    parameter logic [ADDR_W-1:0] DOORBELL = 48'h0000_2000_0040
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_NODES*PINS_PER_NODE-1:0] irq_in,
    input  logic                               cfg_wr,
    input  logic                               cfg_rd,
    input  logic [15:0]                        cfg_addr,
    input  logic [31:0]                        cfg_wdata,
    output logic [31:0]                        cfg_rdata,
    output logic                               msg_valid,
    input  logic                               msg_ready,
    output logic [ADDR_W-1:0]                  msg_addr,
    output logic [DEV_W-1:0]                   msg_device_id,
    output logic [EVT_W-1:0]                   msg_event_id
);
    localparam int NPINS     = NUM_NODES * PINS_PER_NODE;
    localparam int IDX_W     = $clog2(NPINS);
    localparam int RSV_WORDS = RESERVED_PINS / 32;
    localparam int CLR_WORDS = RSV_WORDS + NPINS / 32;
    localparam logic [15:0] CLR_END = 16'(int'(CLR_BASE) + 4 * CLR_WORDS);

    typedef struct packed {
        logic [NPINS-1:0]       lvl;
        vec_t [NPINS-1:0]       vec;
        logic [31:0]            rdata;
        logic                   mvalid;
        vec_t                   mvec;
    } top_t;

    top_t s_d, s_q;

    logic [NPINS-1:0] pend, req, take, clr;
    logic             gnt_v, load;
    logic [IDX_W-1:0] gnt_idx;

    // address decode
    logic clr_hit, clr_pins, node_ok, type_hit, vec_hit;
    int   node_n, clr_lw, type_w, vec_idx;

    always_comb begin
        node_n   = int'(cfg_addr[15:12]);
        clr_hit  = (cfg_addr >= CLR_BASE) && (cfg_addr < CLR_END);
        clr_lw   = int'((cfg_addr - CLR_BASE) >> 2) - RSV_WORDS;
        clr_pins = clr_hit && (clr_lw >= 0);
        node_ok  = !clr_hit && (node_n >= 1) && (node_n <= NUM_NODES);
        type_hit = node_ok && (cfg_addr[11:4] == 8'h00);
        vec_hit  = node_ok && (cfg_addr[11:9] == 3'b001);
        type_w   = (node_n - 1) * (PINS_PER_NODE / 32) + int'(cfg_addr[3:2]);
        vec_idx  = (node_n - 1) * PINS_PER_NODE + int'(cfg_addr[8:2]);
    end

    always_comb begin
        clr = '0;
        if (cfg_wr && clr_pins) clr[clr_lw*32 +: 32] = cfg_wdata;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NPINS; gi++) begin : g_pin
            wim_pin_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .irq_i   (irq_in[gi]),
                .level_i (s_q.lvl[gi]),
                .clr_i   (clr[gi]),
                .take_i  (take[gi]),
                .pend_o  (pend[gi]),
                .req_o   (req[gi])
            );
        end
    endgenerate

    wim_rr_arb #(.N(NPINS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .adv_i     (load),
        .gnt_v_o   (gnt_v),
        .gnt_idx_o (gnt_idx)
    );

    assign load = gnt_v && (!s_q.mvalid || msg_ready);

    always_comb begin
        s_d  = s_q;
        take = '0;
        // message output stage
        if (load) begin
            s_d.mvalid    = 1'b1;
            s_d.mvec      = s_q.vec[gnt_idx];
            take[gnt_idx] = 1'b1;
        end else if (msg_ready) begin
            s_d.mvalid = 1'b0;
        end
        // register writes
        if (cfg_wr && type_hit) s_d.lvl[type_w*32 +: 32] = cfg_wdata;
        if (cfg_wr && vec_hit)  s_d.vec[vec_idx] = cfg_wdata[EVT_W+DEV_W-1:0];
        // register reads
        if (cfg_rd) begin
            s_d.rdata = '0;
            if (clr_pins)      s_d.rdata = pend[clr_lw*32 +: 32];
            else if (type_hit) s_d.rdata = s_q.lvl[type_w*32 +: 32];
            else if (vec_hit)  s_d.rdata = {{(32-EVT_W-DEV_W){1'b0}}, s_q.vec[vec_idx]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_rdata     = s_q.rdata;
    assign msg_valid     = s_q.mvalid;
    assign msg_addr      = DOORBELL;
    assign msg_device_id = s_q.mvec.dev;
    assign msg_event_id  = s_q.mvec.evt;

    // R8: a stalled message keeps its payload
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable({msg_event_id, msg_device_id})));
    // R9: at most one pin is taken per cycle
    p_one_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
    // R6: a taken pin stops requesting on the next cycle unless cleared
    p_taken_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr[gnt_idx]) |=> !req[$past(gnt_idx)]);
endmodule

// File: tb/tb_wim_top.sv
`timescale 1ns/1ps
module tb_wim_top;
    localparam logic [47:0] DB = 48'h0000_2000_0040;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] irq = '0;
    logic         cfg_wr = 1'b0, cfg_rd = 1'b0, msg_ready = 1'b0;
    logic [15:0]  cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [31:0]  cfg_rdata;
    logic         msg_valid;
    logic [47:0]  msg_addr;
    logic [11:0]  msg_device_id;
    logic [9:0]   msg_event_id;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wim_top #(.NUM_NODES(1), .ADDR_W(48), .DOORBELL(DB)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_device_id(msg_device_id), .msg_event_id(msg_event_id)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk); cfg_rd = 1; cfg_addr = a;
        @(negedge clk); cfg_rd = 0; d = cfg_rdata;
    endtask

    // Waits for a message, accepts it, and returns its payload
    task automatic get_msg(output bit got, output logic [11:0] dev, output logic [9:0] evt,
                           output logic [47:0] adr);
        got = 0; dev = '0; evt = '0; adr = '0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (msg_valid) begin
                got = 1; dev = msg_device_id; evt = msg_event_id; adr = msg_addr;
                msg_ready = 1;
                @(negedge clk); msg_ready = 0;
                break;
            end
        end
    endtask

    task automatic quiet(input string req);
        bit seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        check(!seen, req, 64'(seen), 64'd0);
    endtask

    function automatic logic [15:0] clr_addr(input int pin);
        return 16'(32'hA000 + 4 * ((64 + pin) / 32));
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        check(msg_valid == 0, "R1 valid", 64'(msg_valid), 0);
        rd(16'h1200, d); check(d == 0, "R1 vector", 64'(d), 0);
        rd(16'h1000, d); check(d == 0, "R1 type", 64'(d), 0);
        rd(16'hA008, d); check(d == 0, "R1 status", 64'(d), 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(16'h1200 + 16'd20, 32'hFFFF_FFFF);
        rd(16'h1200 + 16'd20, d); check(d == 32'h003F_FFFF, "R2 upper bits zero", 64'(d), 64'h3FFFFF);
        wr(16'h1200 + 16'd20, 32'h002A_B5CD);
        rd(16'h1200 + 16'd20, d); check(d == 32'h002A_B5CD, "R2 vector readback", 64'(d), 64'h2AB5CD);
        wr(16'h1004, 32'h0000_0100);
        rd(16'h1004, d); check(d == 32'h0000_0100, "R3 type readback", 64'(d), 64'h100);
        rd(16'h1000, d); check(d == 0, "R3 other type word", 64'(d), 0);
    endtask

    task automatic t_edge;
        bit got; logic [11:0] dev; logic [9:0] evt; logic [47:0] adr; logic [31:0] d;
        @(negedge clk); irq[5] = 1;
        get_msg(got, dev, evt, adr);
        check(got, "R4 edge message", 64'(got), 1);
        check(dev == 12'h5CD && evt == 10'h2AB, "R8 payload", {evt, dev}, 64'h2AB5CD);
        check(adr == DB, "R8 doorbell", 64'(adr), 64'(DB));
        @(negedge clk); irq[5] = 0;
        repeat (3) @(negedge clk); irq[5] = 1;
        quiet("R6 no second message");
        rd(clr_addr(5), d); check(d[5], "R7 status read", 64'(d), 64'h20);
        wr(clr_addr(5), 32'h0);
        rd(clr_addr(5), d); check(d[5], "R7 write zero no effect", 64'(d), 64'h20);
        wr(clr_addr(5), 32'h20);
        rd(clr_addr(5), d); check(d == 0, "R7 write one clears", 64'(d), 0);
        quiet("R4 held high after clear");
        @(negedge clk); irq[5] = 0;
    endtask

    task automatic t_level;
        bit got; logic [11:0] dev; logic [9:0] evt; logic [47:0] adr; logic [31:0] d;
        wr(16'h1200 + 16'd160, 32'h0000_1028);
        @(negedge clk); irq[40] = 1;
        get_msg(got, dev, evt, adr);
        check(got && dev == 12'h028 && evt == 10'h001, "R5 level message", {evt, dev}, 64'h1028);
        wr(clr_addr(40), 32'h100);
        get_msg(got, dev, evt, adr);
        check(got && dev == 12'h028, "R5 refire while high", 64'(got), 1);
        @(negedge clk); irq[40] = 0;
        repeat (3) @(negedge clk);
        wr(clr_addr(40), 32'h100);
        quiet("R5 no refire when low");
        rd(clr_addr(40), d); check(d == 0, "R5 status clear", 64'(d), 0);
    endtask

    task automatic t_rr;
        bit got; logic [11:0] dev; logic [9:0] evt; logic [47:0] adr;
        for (int i = 0; i < 7; i++) wr(16'(32'h1200 + 4 * i), 32'(12'h100 + i));
        @(negedge clk); irq[2:0] = 3'b111;
        for (int i = 0; i < 3; i++) begin
            get_msg(got, dev, evt, adr);
            check(got && dev == 12'(12'h100 + i), "R9 burst order", 64'(dev), 64'(12'h100 + i));
        end
        @(negedge clk); irq[2:0] = 0;
        wr(clr_addr(0), 32'h7);
        @(negedge clk); irq[0] = 1; irq[6] = 1;
        get_msg(got, dev, evt, adr);
        check(got && dev == 12'h106, "R9 wrap after pointer", 64'(dev), 64'h106);
        get_msg(got, dev, evt, adr);
        check(got && dev == 12'h100, "R9 second grant", 64'(dev), 64'h100);
        @(negedge clk); irq[0] = 0; irq[6] = 0;
        wr(clr_addr(0), 32'h41);
    endtask

    task automatic t_hold;
        bit ok = 1; bit got; logic [11:0] dev; logic [9:0] evt; logic [47:0] adr;
        wr(16'h1200 + 16'd40, 32'h003F_F10A);
        @(negedge clk); irq[10] = 1; irq[11] = 1;
        for (int i = 0; i < 16 && !msg_valid; i++) @(negedge clk);
        dev = msg_device_id;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!msg_valid || msg_device_id != dev || msg_event_id != 10'h3FF) ok = 0;
        end
        check(ok && dev == 12'h10A, "R8 stalled message stable", 64'(dev), 64'h10A);
        get_msg(got, dev, evt, adr);
        get_msg(got, dev, evt, adr);
        check(got && dev == 12'h000, "R8 queued pin after stall", 64'(dev), 0);
        @(negedge clk); irq[11] = 0;
        wr(clr_addr(11), 32'h800);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        wr(16'hA000, 32'hFFFF_FFFF);
        wr(16'hA004, 32'hFFFF_FFFF);
        rd(clr_addr(10), d); check(d[10], "R10 reserved clear ignored", 64'(d), 64'h400);
        rd(16'hA000, d); check(d == 0, "R10 reserved status reads zero", 64'(d), 0);
        rd(16'hA018, d); check(d == 0, "R10 status past last pin", 64'(d), 0);
        wr(16'h0200, 32'h123);
        rd(16'h0200, d); check(d == 0, "R10 node zero reads zero", 64'(d), 0);
        wr(16'h2200, 32'h456);
        rd(16'h2200, d); check(d == 0, "R10 absent node reads zero", 64'(d), 0);
        rd(16'h1200, d); check(d == 32'h100, "R10 real vector untouched", 64'(d), 64'h100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regs();
        t_edge();
        t_level();
        t_rr();
        t_hold();
        t_reserved();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule